// File: doc/BRIEF.md
# Conversion Auto-Trigger Selector

This block decides when an analog-to-digital converter should begin a new conversion while automatic triggering is on. Seven event flags arrive as levels: the converter's own conversion-complete flag, an analog comparator flag, external interrupt 0, timer compare A, timer overflow, timer compare B and pin change. A 3-bit source code picks one of these flags. The block watches the picked signal, taken after the multiplexer, for a rising edge.

Because edge detection sits after the multiplexer, changing the source code can create an edge by itself. Moving from a source whose flag is low to one whose flag is high starts a conversion. Moving into free-running mode never does. In free-running mode the picked signal is the conversion-complete flag, so each finished conversion starts the next one. The output is a single-clock start pulse, registered one clock after the qualifying edge. It is gated by the converter enable and held off while the converter reports busy. A software start request is ORed in.

Top module: `adc_trig_sel`

## Requirements
- R1: With auto-trigger and converter enable high, a rising edge on the flag picked by `srcSel` (0 conversion-complete, 1 comparator, 2 external interrupt 0, 3 timer compare A, 4 timer overflow, 5 timer compare B, 6 pin change) raises `startPulse` on the following clock.
- R2: While `autoEn` is 0, neither the source code nor any flag edge produces a start.
- R3: While `convEn` is 0, no start is produced from any cause, including `swStart`.
- R4: Changing `srcSel` from a source whose flag is 0 to one whose flag is 1 counts as a rising edge and starts a conversion.
- R5: Changing `srcSel` to code 0 from any other code never starts a conversion, even when the conversion-complete flag is already 1.
- R6: In code 0, every rising edge of the conversion-complete flag starts a new conversion.
- R7: Code 7 is reserved; no flag activity starts a conversion while it is selected.
- R8: A start is suppressed in any cycle in which `convBusy` is 1.
- R9: `startPulse` is high for one clock only; a flag that stays high does not start again.
- R10: The edge register follows the picked flag while `autoEn` is 0, so enabling auto-trigger while that flag is already high does not start a conversion.
- R11: `swStart` with `convEn` high and `convBusy` low starts a conversion regardless of `autoEn` or `srcSel`.
- R12: After reset `startPulse` is 0 and the edge register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| convDoneFlag | input | 1 | Conversion-complete flag level |
| cmpFlag | input | 1 | Analog comparator flag level |
| extInt0Flag | input | 1 | External interrupt 0 flag level |
| tmrCmpAFlag | input | 1 | Timer compare A flag level |
| tmrOvfFlag | input | 1 | Timer overflow flag level |
| tmrCmpBFlag | input | 1 | Timer compare B flag level |
| pinChgFlag | input | 1 | Pin change flag level |
| srcSel | input | 3 | Trigger source code |
| autoEn | input | 1 | Auto-trigger enable |
| convEn | input | 1 | Converter enable |
| convBusy | input | 1 | Converter busy, blocks starts |
| swStart | input | 1 | Software start request |
| startPulse | output | 1 | One-clock start-conversion pulse |

## Verification
The bench targets edges created by the multiplexer itself. It switches codes while the target flag is already high, which a design that only watched raw flag edges would miss. It also switches into free-running mode with conversion-complete high, where a design without the mask would fire a spurious start. It re-enables auto-trigger with a flag held high, which exposes an edge register that froze while disabled. Other checks cover the reserved code, busy gating and held flags: a design that retriggered on levels would pulse for several clocks.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int NUM_SRC = 7;
  localparam int SEL_W   = $clog2(NUM_SRC + 1);

  typedef enum logic [SEL_W-1:0] {
    SRC_FREE = 3'd0,
    SRC_ACMP = 3'd1,
    SRC_EXT0 = 3'd2,
    SRC_CMPA = 3'd3,
    SRC_OVF  = 3'd4,
    SRC_CMPB = 3'd5,
    SRC_PCHG = 3'd6,
    SRC_RSVD = 3'd7
  } trigSrcE;

  // strobes from datapath to control
  typedef struct packed {
    logic edgeSeen;   // picked flag rose this cycle
    logic enterFree;  // selection just moved into free-running
    logic selValid;   // code maps to a real source
  } trigStrobesT;
endpackage

// File: rtl/adc_trig_dp.sv
module adc_trig_dp
  import adc_trig_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int SW   = SEL_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] flagVec,
  input  logic [SW-1:0]   srcSel,
  output trigStrobesT     strobes
);
  logic          muxFlag;
  logic          prevFlag;
  logic [SW-1:0] prevSel;

  // source multiplexer; codes past the last source read as 0
  always_comb begin
    muxFlag = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (srcSel == SW'(i)) muxFlag = flagVec[i];
    end
  end

  // edge register tracks the picked flag every cycle, enabled or not
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevFlag <= 1'b0;
      prevSel  <= '0;
    end else begin
      prevFlag <= muxFlag;
      prevSel  <= srcSel;
    end
  end

  always_comb begin
    strobes.edgeSeen  = muxFlag & ~prevFlag;
    strobes.enterFree = (srcSel == SW'(SRC_FREE)) && (prevSel != SW'(SRC_FREE));
    strobes.selValid  = ({1'b0, srcSel} < (SW + 1)'(NSRC));
  end
endmodule

// File: rtl/adc_trig_ctl.sv
module adc_trig_ctl
  import adc_trig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  trigStrobesT strobes,
  input  logic        autoEn,
  input  logic        convEn,
  input  logic        convBusy,
  input  logic        swStart,
  output logic        startPulse
);
  logic autoReq;
  logic fire;

  always_comb begin
    autoReq = autoEn & strobes.selValid & strobes.edgeSeen & ~strobes.enterFree;
    fire    = convEn & ~convBusy & (autoReq | swStart) & ~startPulse;
  end

  always_ff @(posedge clk) begin
    if (!rstN) startPulse <= 1'b0;
    else       startPulse <= fire;
  end
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             convDoneFlag,
  input  logic             cmpFlag,
  input  logic             extInt0Flag,
  input  logic             tmrCmpAFlag,
  input  logic             tmrOvfFlag,
  input  logic             tmrCmpBFlag,
  input  logic             pinChgFlag,
  input  logic [SEL_W-1:0] srcSel,
  input  logic             autoEn,
  input  logic             convEn,
  input  logic             convBusy,
  input  logic             swStart,
  output logic             startPulse
);
  logic [NUM_SRC-1:0] flagVec;
  trigStrobesT        strobes;

  // bit order follows the source code
  assign flagVec = {pinChgFlag, tmrCmpBFlag, tmrOvfFlag, tmrCmpAFlag,
                    extInt0Flag, cmpFlag, convDoneFlag};

  adc_trig_dp #(.NSRC(NUM_SRC), .SW(SEL_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .flagVec (flagVec),
    .srcSel  (srcSel),
    .strobes (strobes)
  );

  adc_trig_ctl ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .autoEn     (autoEn),
    .convEn     (convEn),
    .convBusy   (convBusy),
    .swStart    (swStart),
    .startPulse (startPulse)
  );
endmodule

// File: rtl/adc_trig_chk.sv
module adc_trig_chk
  import adc_trig_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [SEL_W-1:0] srcSel,
  input logic             autoEn,
  input logic             convEn,
  input logic             convBusy,
  input logic             swStart,
  input logic             startPulse
);
  logic pastOk;
  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  // R3
  conv_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && startPulse) |-> $past(convEn));

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && startPulse) |-> !$past(convBusy));

  // R2
  auto_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && startPulse && !$past(swStart)) |-> $past(autoEn));

  // R7
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && startPulse && !$past(swStart)) |->
      ({1'b0, $past(srcSel)} < (SEL_W + 1)'(NUM_SRC)));

  // R5
  free_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && srcSel == '0 && $past(srcSel) != '0 && !swStart) |=> !startPulse);
endmodule

bind adc_trig_sel adc_trig_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .srcSel     (srcSel),
  .autoEn     (autoEn),
  .convEn     (convEn),
  .convBusy   (convBusy),
  .swStart    (swStart),
  .startPulse (startPulse)
);

// File: tb/adc_trig_sel_tb.sv
module adc_trig_sel_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] flags = '0;
  logic [2:0] srcSel = '0;
  logic       autoEn = 1'b0, convEn = 1'b0, convBusy = 1'b0, swStart = 1'b0;
  logic       startPulse;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    bit    exp;
    string tag;
  } expItemT;
  expItemT expQ[$];

  always #10 clk = ~clk;

  adc_trig_sel dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .convDoneFlag (flags[0]),
    .cmpFlag      (flags[1]),
    .extInt0Flag  (flags[2]),
    .tmrCmpAFlag  (flags[3]),
    .tmrOvfFlag   (flags[4]),
    .tmrCmpBFlag  (flags[5]),
    .pinChgFlag   (flags[6]),
    .srcSel       (srcSel),
    .autoEn       (autoEn),
    .convEn       (convEn),
    .convBusy     (convBusy),
    .swStart      (swStart),
    .startPulse   (startPulse)
  );

  // driver: apply one cycle of inputs, queue expected pulse for the next edge
  task automatic step(input logic [2:0] sel, input bit au, input bit en,
                      input bit busy, input bit sw, input logic [6:0] fl,
                      input bit exp, input string tag);
    @(negedge clk);
    srcSel = sel; autoEn = au; convEn = en; convBusy = busy; swStart = sw; flags = fl;
    expQ.push_back('{exp, tag});
  endtask

  // monitor: compare after the edge that registers the result
  always @(posedge clk) begin
    #5;
    if (rstN && expQ.size() > 0) begin
      expItemT it;
      it = expQ.pop_front();
      checks++;
      if (startPulse !== it.exp) begin
        errors++;
        $display("FAIL %s: startPulse=%0b expected=%0b", it.tag, startPulse, it.exp);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (startPulse !== 1'b0) begin
      errors++;
      $display("FAIL R12: startPulse=%0b expected=0", startPulse);
    end
    step(3'd1, 1, 1, 0, 0, 7'h00, 0, "R12");

    // R1 and R9: every real source code, one pulse per edge
    for (int c = 1; c < 7; c++) begin
      step(3'(c), 1, 1, 0, 0, 7'h00, 0, "R1");
      step(3'(c), 1, 1, 0, 0, 7'(1 << c), 1, "R1");
      step(3'(c), 1, 1, 0, 0, 7'(1 << c), 0, "R9");
      step(3'(c), 1, 1, 0, 0, 7'h00, 0, "R1");
    end

    // R6 free-running retrigger
    step(3'd0, 1, 1, 0, 0, 7'h00, 0, "R6");
    step(3'd0, 1, 1, 0, 0, 7'h01, 1, "R6");
    step(3'd0, 1, 1, 0, 0, 7'h00, 0, "R6");
    step(3'd0, 1, 1, 0, 0, 7'h01, 1, "R6");
    step(3'd0, 1, 1, 0, 0, 7'h00, 0, "R6");

    // R4 selection switch creates an edge
    step(3'd1, 1, 1, 0, 0, 7'h04, 0, "R4");
    step(3'd2, 1, 1, 0, 0, 7'h04, 1, "R4");
    step(3'd2, 1, 1, 0, 0, 7'h04, 0, "R4");

    // R5 switch into free-running with conversion-complete high
    step(3'd1, 1, 1, 0, 0, 7'h01, 0, "R5");
    step(3'd0, 1, 1, 0, 0, 7'h01, 0, "R5");
    step(3'd0, 1, 1, 0, 0, 7'h01, 0, "R5");
    step(3'd0, 1, 1, 0, 0, 7'h00, 0, "R5");

    // R7 reserved code
    step(3'd7, 1, 1, 0, 0, 7'h00, 0, "R7");
    step(3'd7, 1, 1, 0, 0, 7'h7F, 0, "R7");
    step(3'd7, 1, 1, 0, 0, 7'h00, 0, "R7");

    // R2 disabled, R10 re-enable while flag high
    step(3'd1, 0, 1, 0, 0, 7'h00, 0, "R2");
    step(3'd1, 0, 1, 0, 0, 7'h02, 0, "R2");
    step(3'd2, 0, 1, 0, 0, 7'h06, 0, "R2");
    step(3'd1, 1, 1, 0, 0, 7'h02, 0, "R10");
    step(3'd1, 1, 1, 0, 0, 7'h00, 0, "R10");

    // R3 converter disabled
    step(3'd1, 1, 0, 0, 0, 7'h02, 0, "R3");
    step(3'd1, 1, 0, 0, 1, 7'h00, 0, "R3");
    step(3'd1, 1, 1, 0, 0, 7'h00, 0, "R3");

    // R8 busy blocks start
    step(3'd1, 1, 1, 1, 0, 7'h02, 0, "R8");
    step(3'd1, 1, 1, 0, 0, 7'h00, 0, "R8");

    // R11 software start with auto-trigger off
    step(3'd7, 0, 1, 0, 1, 7'h00, 1, "R11");
    step(3'd7, 0, 1, 0, 0, 7'h00, 0, "R11");

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule